// File: doc/BRIEF.md
# SDRAM bank command sequencer

This block turns simple read and write requests into commands for a single-data-rate SDRAM. Each request carries a bank, a row and a column, a read/write flag and an auto-precharge flag. The sequencer keeps one open-row record per bank across four banks. A request to the row already open goes straight to a column command. A request to a different row closes that bank first, then opens the new row, then issues the column command. A request to a closed bank opens the row first.

Every minimum spacing between commands is a whole number of clocks fixed at elaboration time. Each count is a nanosecond figure divided by the clock period and rounded up. Each bank has its own activate-to-column, activate-to-precharge, activate-to-activate and precharge-to-activate timers. Shared timers cover activates across banks, the settle time after a mode register write, and the burst that runs after a column command with auto precharge. After reset the block closes all banks and writes the mode register before it accepts any request.

The state machine has six states. S_RST_PALL issues a precharge to all banks and always moves to S_RST_MRS. S_RST_MRS issues the mode register write once every bank's precharge time has passed, then moves to S_IDLE. S_IDLE accepts a request on a valid/ready handshake and moves to S_COL on a row hit, to S_PRE on a row miss, or to S_ACT when the bank is closed. S_PRE closes the bank once its minimum active time is met, then moves to S_ACT. S_ACT opens the row once the bank's precharge and row-cycle times and the cross-bank activate spacing are met, then moves to S_COL. S_COL issues the read or write once the bank's activate-to-column time is met and no auto-precharge burst is running, then returns to S_IDLE.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is asserted, the command bus carries a no-op, req_ready is low and init_done is low.
- R2: Commands are driven active-low on {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}: activate 0011, read 0101, write 0100, precharge 0010, mode register set 0000, no-op 0111. For activate, precharge, read and write, sd_ba carries the bank number (0 to 3).
- R3: After reset the first command is a precharge with sd_addr[10]=1, which closes all banks. It is followed, at least T_RP clocks later, by a mode register set. That command has CAS_LAT in sd_addr[6:4], log2(BURST_LEN) in sd_addr[2:0] and 0 in every other bit (0x032 by default). init_done rises in the cycle the mode register set is on the bus.
- R4: req_ready is low in the cycle the mode register set is on the bus and high T_MRD-1 clocks later. No other command follows it within T_MRD clocks.
- R5: A request to the open row of its bank produces only a column command. A request to another row of an open bank produces a precharge of that bank, then an activate, then a column command. A request to a closed bank produces an activate, then a column command. An activate carries the row on sd_addr.
- R6: A read or write carries the column on sd_addr[9:0] and the auto-precharge flag on sd_addr[10]. A single-bank precharge has sd_addr[10]=0.
- R7: Within one bank, activate to column is at least T_RCD clocks, activate to precharge at least T_RAS, precharge to activate at least T_RP, and activate to activate at least T_RC.
- R8: Activates to any two banks are at least T_RRD clocks apart.
- R9: A column command with auto precharge closes its bank. The next column command to any bank is at least BURST_LEN clocks later. The next activate of that bank is at least BURST_LEN+T_RP clocks later. The command itself is issued no earlier than T_RAS-BURST_LEN clocks after that bank's activate.
- R10: With no timer pending, a row hit puts its column command on the bus 1 clock after the accepting edge. A request to a closed bank puts its activate on the bus 1 clock after the accepting edge and its column command T_RCD clocks after the activate.
- R11: req_ready is high only when init_done is high. It goes low in the cycle after a request is accepted and stays low until that request's column command has been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the bank after this access |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 10 | Target column |
| init_done | output | 1 | Power-up sequence finished |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Multiplexed row/column address |

## Verification
Commands are registered, so every command appears on the bus one clock after the cycle in which its timers clear. From an idle start, a row-hit column command is due 1 clock after the accepting edge. For a closed bank the activate is due at 1 clock and the column command at 1+T_RCD clocks. The bench samples on falling edges, logs every non-no-op command with its cycle number, and compares the log against a row-tracking model of the requests. It checks each logged pair of commands against its minimum spacing. On the two directed requests started from an idle, settled state it checks the exact cycle offsets. It checks req_ready in the cycle after each accepted request and in the first two cycles after the mode register set.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    // Active-low {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_BST = 4'b0110,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        S_RST_PALL,
        S_RST_MRS,
        S_IDLE,
        S_PRE,
        S_ACT,
        S_COL
    } seq_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_dly_cnt.sv
// Loadable down-counter that stops at zero; a command is allowed when it reads zero.
module sdram_dly_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic [W-1:0] cnt_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/sdram_bank_state.sv
// Open-row record and per-bank spacing timers for one bank.
module sdram_bank_state
    import sdram_seq_pkg::*;
#(
    parameter int ROW_W     = 13,
    parameter int T_RCD     = 3,
    parameter int T_RAS     = 6,
    parameter int T_RC      = 9,
    parameter int T_RP      = 3,
    parameter int BURST_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             pre_i,
    input  logic             colap_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             act_ok_o,
    output logic             pre_ok_o,
    output logic             col_ok_o,
    output logic             ap_ok_o
);

    localparam int AP_RP = BURST_LEN + T_RP;
    localparam int MAXV  = max2(max2(max2(T_RAS, T_RC), max2(T_RCD, AP_RP)), BURST_LEN);
    localparam int CW    = $clog2(MAXV + 1);

    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic [CW-1:0]    rcd_cnt;
    logic [CW-1:0]    ras_cnt;
    logic [CW-1:0]    rc_cnt;
    logic [CW-1:0]    rp_cnt;
    logic [CW-1:0]    rp_val;
    logic             rp_load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            row_q  <= '0;
        end else if (act_i) begin
            open_q <= 1'b1;
            row_q  <= row_i;
        end else if (pre_i || colap_i) begin
            open_q <= 1'b0;
        end
    end

    assign rp_load = pre_i | colap_i;
    assign rp_val  = colap_i ? CW'(AP_RP - 1) : CW'(T_RP - 1);

    sdram_dly_cnt #(.W(CW)) u_rcd (
        .clk(clk), .rst_n(rst_n), .load_i(act_i),
        .val_i(CW'(T_RCD - 1)), .cnt_o(rcd_cnt)
    );

    sdram_dly_cnt #(.W(CW)) u_ras (
        .clk(clk), .rst_n(rst_n), .load_i(act_i),
        .val_i(CW'(T_RAS - 1)), .cnt_o(ras_cnt)
    );

    sdram_dly_cnt #(.W(CW)) u_rc (
        .clk(clk), .rst_n(rst_n), .load_i(act_i),
        .val_i(CW'(T_RC - 1)), .cnt_o(rc_cnt)
    );

    sdram_dly_cnt #(.W(CW)) u_rp (
        .clk(clk), .rst_n(rst_n), .load_i(rp_load),
        .val_i(rp_val), .cnt_o(rp_cnt)
    );

    assign open_o   = open_q;
    assign row_o    = row_q;
    assign act_ok_o = !open_q && (rc_cnt == '0) && (rp_cnt == '0);
    assign pre_ok_o = (ras_cnt == '0);
    assign col_ok_o = open_q && (rcd_cnt == '0);
    // internal precharge starts BURST_LEN clocks after the column command
    assign ap_ok_o  = (ras_cnt < CW'(BURST_LEN));

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int BA_W      = 2,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 10,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RAS     = 6,
    parameter int T_RC      = 9,
    parameter int T_RRD     = 2,
    parameter int T_MRD     = 2,
    parameter int BURST_LEN = 4,
    parameter int CAS_LAT   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic             req_autopre,
    input  logic [BA_W-1:0]  req_bank,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    output logic             init_done,
    output logic             sd_cs_n,
    output logic             sd_ras_n,
    output logic             sd_cas_n,
    output logic             sd_we_n,
    output logic [BA_W-1:0]  sd_ba,
    output logic [ROW_W-1:0] sd_addr
);

    localparam int NBANK  = 1 << BA_W;
    localparam int AP_BIT = 10;
    localparam int GMAX   = max2(max2(T_RRD, T_MRD), BURST_LEN);
    localparam int GW     = $clog2(GMAX + 1);
    localparam logic [ROW_W-1:0] MODE_WORD =
        ROW_W'((CAS_LAT << 4) | $clog2(BURST_LEN));

    seq_state_e state_q, state_d;

    logic             lat_wr, lat_ap;
    logic [BA_W-1:0]  lat_bank;
    logic [ROW_W-1:0] lat_row;
    logic [COL_W-1:0] lat_col;

    logic [NBANK-1:0] bk_open, bk_act_ok, bk_pre_ok, bk_col_ok, bk_ap_ok;
    logic [ROW_W-1:0] bk_row [NBANK];
    logic [NBANK-1:0] bk_act, bk_pre, bk_colap;

    logic fire_pall, fire_mrs, fire_pre, fire_act, fire_col;
    logic accept;

    logic [GW-1:0] rrd_cnt, mrd_cnt, blk_cnt;
    logic          rrd_clear, mrd_clear, blk_clear;

    sd_cmd_e          cmd_q;
    logic [BA_W-1:0]  ba_q;
    logic [ROW_W-1:0] addr_q;
    logic [ROW_W-1:0] col_addr;

    // ---------------- per-bank trackers ----------------
    generate
        for (genvar gi = 0; gi < NBANK; gi++) begin : g_bank
            assign bk_act[gi]   = fire_act && (lat_bank == BA_W'(gi));
            assign bk_pre[gi]   = fire_pall || (fire_pre && (lat_bank == BA_W'(gi)));
            assign bk_colap[gi] = fire_col && lat_ap && (lat_bank == BA_W'(gi));

            sdram_bank_state #(
                .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RAS(T_RAS),
                .T_RC(T_RC), .T_RP(T_RP), .BURST_LEN(BURST_LEN)
            ) u_bank (
                .clk(clk),
                .rst_n(rst_n),
                .act_i(bk_act[gi]),
                .pre_i(bk_pre[gi]),
                .colap_i(bk_colap[gi]),
                .row_i(lat_row),
                .open_o(bk_open[gi]),
                .row_o(bk_row[gi]),
                .act_ok_o(bk_act_ok[gi]),
                .pre_ok_o(bk_pre_ok[gi]),
                .col_ok_o(bk_col_ok[gi]),
                .ap_ok_o(bk_ap_ok[gi])
            );
        end
    endgenerate

    // ---------------- shared timers ----------------
    sdram_dly_cnt #(.W(GW)) u_rrd (
        .clk(clk), .rst_n(rst_n), .load_i(fire_act),
        .val_i(GW'(T_RRD - 1)), .cnt_o(rrd_cnt)
    );

    sdram_dly_cnt #(.W(GW)) u_mrd (
        .clk(clk), .rst_n(rst_n), .load_i(fire_mrs),
        .val_i(GW'(T_MRD - 1)), .cnt_o(mrd_cnt)
    );

    sdram_dly_cnt #(.W(GW)) u_blk (
        .clk(clk), .rst_n(rst_n), .load_i(fire_col && lat_ap),
        .val_i(GW'(BURST_LEN - 1)), .cnt_o(blk_cnt)
    );

    assign rrd_clear = (rrd_cnt == '0);
    assign mrd_clear = (mrd_cnt == '0);
    assign blk_clear = (blk_cnt == '0);

    assign req_ready = (state_q == S_IDLE) && mrd_clear && blk_clear;
    assign accept    = req_valid && req_ready;
    assign init_done = (state_q != S_RST_PALL) && (state_q != S_RST_MRS);

    // ---------------- next state and command choice ----------------
    always_comb begin
        state_d   = state_q;
        fire_pall = 1'b0;
        fire_mrs  = 1'b0;
        fire_pre  = 1'b0;
        fire_act  = 1'b0;
        fire_col  = 1'b0;
        unique case (state_q)
            S_RST_PALL: begin
                fire_pall = 1'b1;
                state_d   = S_RST_MRS;
            end
            S_RST_MRS: begin
                if (&bk_act_ok) begin
                    fire_mrs = 1'b1;
                    state_d  = S_IDLE;
                end
            end
            S_IDLE: begin
                if (accept) begin
                    if (!bk_open[req_bank]) begin
                        state_d = S_ACT;
                    end else if (bk_row[req_bank] == req_row) begin
                        state_d = S_COL;
                    end else begin
                        state_d = S_PRE;
                    end
                end
            end
            S_PRE: begin
                if (bk_pre_ok[lat_bank]) begin
                    fire_pre = 1'b1;
                    state_d  = S_ACT;
                end
            end
            S_ACT: begin
                if (bk_act_ok[lat_bank] && rrd_clear) begin
                    fire_act = 1'b1;
                    state_d  = S_COL;
                end
            end
            S_COL: begin
                if (bk_col_ok[lat_bank] && blk_clear &&
                    (!lat_ap || bk_ap_ok[lat_bank])) begin
                    fire_col = 1'b1;
                    state_d  = S_IDLE;
                end
            end
            default: state_d = S_RST_PALL;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_RST_PALL;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- request latch ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_wr   <= 1'b0;
            lat_ap   <= 1'b0;
            lat_bank <= '0;
            lat_row  <= '0;
            lat_col  <= '0;
        end else if (accept) begin
            lat_wr   <= req_write;
            lat_ap   <= req_autopre;
            lat_bank <= req_bank;
            lat_row  <= req_row;
            lat_col  <= req_col;
        end
    end

    always_comb begin
        col_addr                = '0;
        col_addr[COL_W-1:0]     = lat_col;
        col_addr[AP_BIT]        = lat_ap;
    end

    // ---------------- registered command bus ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= CMD_NOP;
            ba_q   <= '0;
            addr_q <= '0;
        end else begin
            cmd_q  <= CMD_NOP;
            ba_q   <= '0;
            addr_q <= '0;
            if (fire_pall) begin
                cmd_q          <= CMD_PRE;
                addr_q[AP_BIT] <= 1'b1;
            end else if (fire_mrs) begin
                cmd_q  <= CMD_MRS;
                addr_q <= MODE_WORD;
            end else if (fire_pre) begin
                cmd_q <= CMD_PRE;
                ba_q  <= lat_bank;
            end else if (fire_act) begin
                cmd_q  <= CMD_ACT;
                ba_q   <= lat_bank;
                addr_q <= lat_row;
            end else if (fire_col) begin
                cmd_q  <= lat_wr ? CMD_WR : CMD_RD;
                ba_q   <= lat_bank;
                addr_q <= col_addr;
            end
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
    assign sd_ba   = ba_q;
    assign sd_addr = addr_q;

endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic init_done,
    input logic sd_cs_n,
    input logic sd_ras_n,
    input logic sd_cas_n,
    input logic sd_we_n
);

    logic [3:0] bus;
    logic is_act, is_rd, is_wr, is_mrs, is_nop;

    assign bus    = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_act = (bus == 4'b0011);
    assign is_rd  = (bus == 4'b0101);
    assign is_wr  = (bus == 4'b0100);
    assign is_mrs = (bus == 4'b0000);
    assign is_nop = (bus == 4'b0111);

    // R2
    cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus inside {4'b0000, 4'b0010, 4'b0011, 4'b0100, 4'b0101, 4'b0111});

    // R4
    mrs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |=> is_nop);

    // R8
    act_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |=> !is_act);

    // R7
    act_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |=> !(is_rd || is_wr));

    // R3
    init_mrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> is_mrs);

    // R11
    ready_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> init_done);

endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk chk_i (.*);

// File: tb/sdram_cmd_seq_tb_top.sv
module sdram_cmd_seq_tb_top;

    localparam int T_RCD = 3;
    localparam int T_RP  = 3;
    localparam int T_RAS = 6;
    localparam int T_RC  = 9;
    localparam int T_RRD = 2;
    localparam int T_MRD = 2;
    localparam int BL    = 4;
    localparam int MODE  = 'h032;
    localparam int K_MRS = 0, K_PRE = 2, K_ACT = 3, K_WR = 4, K_RD = 5;

    // {write, autopre, bank[1:0], row[12:0], col[9:0]}
    localparam int NREQ = 11;
    localparam logic [26:0] TBL [NREQ] = '{
        {1'b0, 1'b0, 2'd0, 13'd5,    10'd1},
        {1'b1, 1'b0, 2'd0, 13'd5,    10'd2},
        {1'b0, 1'b0, 2'd1, 13'd7,    10'd3},
        {1'b1, 1'b0, 2'd0, 13'd9,    10'd4},
        {1'b0, 1'b1, 2'd2, 13'd1,    10'd5},
        {1'b1, 1'b0, 2'd2, 13'd1,    10'd6},
        {1'b0, 1'b1, 2'd3, 13'd2,    10'd7},
        {1'b1, 1'b1, 2'd1, 13'd7,    10'd8},
        {1'b0, 1'b0, 2'd1, 13'd8,    10'd9},
        {1'b0, 1'b1, 2'd0, 13'd9,    10'd1023},
        {1'b1, 1'b0, 2'd3, 13'd8191, 10'd0}
    };
    localparam int NALL = NREQ + 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic        req_ready, init_done;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;

    always #5 clk = ~clk;

    sdram_cmd_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_autopre(req_autopre),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .init_done(init_done),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr)
    );

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    int mn = 0;
    int mk [256];
    int mba [256];
    int maddr [256];
    int mcyc [256];

    logic [26:0] all_req [NALL];
    int acc [NALL];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} != 4'b0111 && mn < 256) begin
            mk[mn]    = int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n});
            mba[mn]   = int'(sd_ba);
            maddr[mn] = int'(sd_addr);
            mcyc[mn]  = cyc;
            mn        = mn + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input logic [26:0] v, output int a);
        @(negedge clk);
        {req_write, req_autopre, req_bank, req_row, req_col} = v;
        req_valid = 1'b1;
        forever begin
            if (req_ready) begin
                a = cyc + 1;
                @(negedge clk);
                req_valid = 1'b0;
                break;
            end
            @(negedge clk);
        end
        // R11: ready drops once the request is taken
        check(req_ready == 1'b0, "R11 ready after accept", int'(req_ready), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int ek [128];
        int eba [128];
        int eaddr [128];
        int ne;
        int col_idx [NALL];
        int first_idx [NALL];
        bit m_open [4];
        int m_row [4];
        int last_act [4];
        int last_pre [4];
        int last_apc [4];
        int last_act_any, last_apc_any, last_mrs;
        int w;

        // R1: reset state
        repeat (3) @(negedge clk);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 bus in reset",
              int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
        check(req_ready == 1'b0, "R1 ready in reset", int'(req_ready), 0);
        check(init_done == 1'b0, "R1 init_done in reset", int'(init_done), 0);
        rst_n = 1'b1;

        // R4: ready around the mode register set
        w = 0;
        while (!init_done && w < 100) begin
            @(negedge clk);
            w++;
        end
        check(init_done == 1'b1, "R3 init_done rises", int'(init_done), 1);
        check(req_ready == 1'b0, "R4 ready in MRS cycle", int'(req_ready), 0);
        @(negedge clk);
        check(req_ready == 1'b1, "R4 ready after T_MRD", int'(req_ready), 1);

        for (int i = 0; i < NREQ; i++) all_req[i] = TBL[i];
        all_req[NREQ]     = {1'b0, 1'b0, 2'd3, 13'd8191, 10'd9};  // row hit
        all_req[NREQ + 1] = {1'b1, 1'b0, 2'd0, 13'd3,    10'd4};  // closed bank

        for (int i = 0; i < NREQ; i++) send(all_req[i], acc[i]);
        repeat (50) @(negedge clk);
        send(all_req[NREQ], acc[NREQ]);
        repeat (50) @(negedge clk);
        send(all_req[NREQ + 1], acc[NREQ + 1]);
        repeat (30) @(negedge clk);

        // ---------------- expected command list from the row model ----------------
        ne = 0;
        for (int b = 0; b < 4; b++) begin
            m_open[b] = 1'b0;
            m_row[b]  = 0;
        end
        for (int i = 0; i < NALL; i++) begin
            int bk, rw, cl;
            bit wr, ap;
            wr = all_req[i][26];
            ap = all_req[i][25];
            bk = int'(all_req[i][24:23]);
            rw = int'(all_req[i][22:10]);
            cl = int'(all_req[i][9:0]);
            first_idx[i] = ne;
            if (m_open[bk] && m_row[bk] != rw) begin
                ek[ne] = K_PRE; eba[ne] = bk; eaddr[ne] = 0; ne++;
                m_open[bk] = 1'b0;
            end
            if (!m_open[bk]) begin
                ek[ne] = K_ACT; eba[ne] = bk; eaddr[ne] = rw; ne++;
                m_open[bk] = 1'b1;
                m_row[bk]  = rw;
            end
            col_idx[i] = ne;
            ek[ne] = wr ? K_WR : K_RD; eba[ne] = bk; eaddr[ne] = cl | (int'(ap) << 10); ne++;
            if (ap) m_open[bk] = 1'b0;
        end

        // R3: power-up commands
        check(mn >= 2, "R3 power-up commands logged", mn, 2);
        if (mn >= 2) begin
            check(mk[0] == K_PRE && maddr[0][10] == 1'b1, "R3 first is precharge all", mk[0], K_PRE);
            check(mk[1] == K_MRS, "R3 second is MRS", mk[1], K_MRS);
            check(maddr[1] == MODE, "R3 mode word", maddr[1], MODE);
            check(mcyc[1] - mcyc[0] >= T_RP, "R3 precharge-all to MRS gap", mcyc[1] - mcyc[0], T_RP);
        end

        // R5 R6 R2: command list against model
        check(mn - 2 == ne, "R5 command count", mn - 2, ne);
        for (int i = 0; i < ne && i + 2 < mn; i++) begin
            check(mk[i + 2] == ek[i], "R5 command kind", mk[i + 2], ek[i]);
            check(mba[i + 2] == eba[i], "R2 bank address", mba[i + 2], eba[i]);
            if (ek[i] == K_PRE)
                check(maddr[i + 2][10] == 1'b0, "R6 single-bank precharge A10", maddr[i + 2], 0);
            else if (ek[i] == K_ACT)
                check(maddr[i + 2] == eaddr[i], "R5 activate row", maddr[i + 2], eaddr[i]);
            else
                check(maddr[i + 2][10:0] == eaddr[i][10:0], "R6 column and A10", maddr[i + 2], eaddr[i]);
        end

        // R7 R8 R9 R4: spacing over the logged commands
        for (int b = 0; b < 4; b++) begin
            last_act[b] = -1000; last_pre[b] = -1000; last_apc[b] = -1000;
        end
        last_act_any = -1000; last_apc_any = -1000; last_mrs = -1000;
        for (int j = 0; j < mn; j++) begin
            int t, b;
            t = mcyc[j];
            b = mba[j];
            if (j > 0 && last_mrs > -1000)
                check(t - last_mrs >= T_MRD, "R4 MRS to next command", t - last_mrs, T_MRD);
            if (mk[j] == K_MRS) last_mrs = t;
            else if (mk[j] == K_PRE) begin
                if (maddr[j][10]) begin
                    for (int q = 0; q < 4; q++) last_pre[q] = t;
                end else begin
                    check(t - last_act[b] >= T_RAS, "R7 activate to precharge", t - last_act[b], T_RAS);
                    last_pre[b] = t;
                end
            end else if (mk[j] == K_ACT) begin
                check(t - last_pre[b] >= T_RP, "R7 precharge to activate", t - last_pre[b], T_RP);
                check(t - last_act[b] >= T_RC, "R7 activate to activate same bank", t - last_act[b], T_RC);
                check(t - last_act_any >= T_RRD, "R8 activate to activate any bank", t - last_act_any, T_RRD);
                check(t - last_apc[b] >= BL + T_RP, "R9 auto-precharge to activate", t - last_apc[b], BL + T_RP);
                last_act[b] = t;
                last_act_any = t;
            end else if (mk[j] == K_RD || mk[j] == K_WR) begin
                check(t - last_act[b] >= T_RCD, "R7 activate to column", t - last_act[b], T_RCD);
                check(t - last_apc_any >= BL, "R9 column after auto-precharge burst", t - last_apc_any, BL);
                if (maddr[j][10]) begin
                    check(t - last_act[b] >= T_RAS - BL, "R9 auto-precharge vs active time",
                          t - last_act[b], T_RAS - BL);
                    last_apc[b] = t;
                    last_apc_any = t;
                end
            end
        end

        // R10: exact latency from an idle start
        if (mn - 2 == ne) begin
            check(mcyc[col_idx[NREQ] + 2] == acc[NREQ] + 1, "R10 row-hit column latency",
                  mcyc[col_idx[NREQ] + 2] - acc[NREQ], 1);
            check(mcyc[first_idx[NREQ + 1] + 2] == acc[NREQ + 1] + 1, "R10 closed-bank activate latency",
                  mcyc[first_idx[NREQ + 1] + 2] - acc[NREQ + 1], 1);
            check(mcyc[col_idx[NREQ + 1] + 2] == acc[NREQ + 1] + 1 + T_RCD, "R10 closed-bank column latency",
                  mcyc[col_idx[NREQ + 1] + 2] - acc[NREQ + 1], 1 + T_RCD);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule